// File: doc/BRIEF.md
# Fractionally Spaced Bin-Pair Equalizer

This block sits on the receive side of a block-based multicarrier link, after cyclic-prefix removal and the forward transform. It takes one spectrum of `NBINS` complex bins per block, in natural bin order. Each bin is weighted by its own complex coefficient. Each bin `k` in the lower half is then combined with its partner bin `k + NBINS/2`, and half of the sum is returned. The block therefore folds a twice-oversampled spectrum into `NBINS/2` equalized values, one per symbol-rate bin. A channel notch in one bin of a pair can be made up by the other bin, which is not possible when each bin is simply divided by its own gain.

A lower-half bin is weighted as it arrives and parked until its partner arrives. The output for that pair is produced in the cycle the partner is accepted. Coefficients are loaded through a write port that is open only between blocks. The block does not check that the coefficients satisfy the perfect-equalization condition `C[k]E[k] + C[k+NBINS/2]E[k+NBINS/2] = 2`; the loader is responsible for that. Both streaming sides use valid/ready handshakes with an end-of-block flag. The default size is 128 bins, which gives 64 outputs per block.

Top module: `bin_pair_eq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1. The bin counter starts at bin 0. Every coefficient is 0 (real 0, imaginary 0).
- R2: For input bin `Y = a + jb` and coefficient `E = c + jd`, the weighted product is `(ac − bd) + j(ad + bc)`. It is computed at full precision. Output `k` is half the sum of the products for bins `k` and `k + NBINS/2`, rounded as in R4 and limited as in R5. Real and imaginary parts are handled separately.
- R3: A block of `NBINS` accepted bins with no early end flag gives exactly `NBINS/2` outputs, in order `k = 0 … NBINS/2−1`. `out_last` is 1 only on output `NBINS/2−1`. The bin after bin `NBINS−1` is bin 0 of the next block.
- R4: The halving adds 1 to the full-precision sum and then shifts it right arithmetically by one. So a sum of −1 gives 0, a sum of 1 gives 1, a sum of 3 gives 2 and a sum of −3 gives −1.
- R5: Each output component is limited to the range −32768 … 32767 (for `DW = 16`). A larger halved sum gives 32767 and a smaller one gives −32768.
- R6: A write with `cw_en = 1` stores (`cw_re`, `cw_im`) as the coefficient of bin `cw_idx`. It does so only when the counter is at bin 0 and no bin is accepted in that cycle. At any other time the write is ignored, and later blocks still use the old coefficient.
- R7: While `out_valid = 1` and `out_ready = 0`, the signals `out_valid`, `out_re`, `out_im` and `out_last` do not change.
- R8: While the counter is in the lower half, `in_ready` is 1. While it is in the upper half, `in_ready` is 1 only if no output is pending or the pending output is being taken (`!out_valid || out_ready`).
- R9: A bin accepted with `in_last = 1` ends the block early, and the counter returns to bin 0. If that bin is in the upper half, its pair output is produced with `out_last = 1`. If it is in the lower half, no output is produced for the unfinished block.
- R10: Accepting a lower-half bin produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bin valid |
| in_ready | output | 1 | Block can accept a bin |
| in_re | input | DW | Input bin, real part (signed) |
| in_im | input | DW | Input bin, imaginary part (signed) |
| in_last | input | 1 | Marks the final bin of a block |
| out_valid | output | 1 | Output value valid |
| out_ready | input | 1 | Consumer takes the output |
| out_re | output | DW | Equalized value, real part (signed) |
| out_im | output | DW | Equalized value, imaginary part (signed) |
| out_last | output | 1 | Marks the final output of a block |
| cw_en | input | 1 | Coefficient write strobe |
| cw_idx | input | $clog2(NBINS) | Bin index of the coefficient to write |
| cw_re | input | DW | Coefficient, real part (signed) |
| cw_im | input | DW | Coefficient, imaginary part (signed) |

## Verification
The pair arithmetic is tried with several stimulus sets:
- Unit-real coefficients with small bins show the plain pair average, and whether a bin is matched to the wrong partner.
- Small-magnitude sums near zero of both signs isolate the round-half-up rule.
- Random complex bins and coefficients exercise the sign terms of the cross products.
- Full-scale operands with opposing coefficient signs drive both saturation limits.

Further blocks cover other conditions:
- A coefficient write in mid-block, followed by a write between blocks, separates a gated write from an accepted one.
- A held-off output shows the input stall in the upper half and the stable output.
- End flags in either half test the early return to bin 0.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

   // Which half of the incoming spectrum the bin counter is in.
   typedef enum logic [0:0] {
      SEG_LO = 1'b0,
      SEG_HI = 1'b1
   } seg_t;

   // Number of components in a complex sample.
   localparam int unsigned LANES = 2;

endpackage

// File: rtl/bpe_coef_mem.sv
module bpe_coef_mem #(
   parameter int unsigned NBINS = 128,
   parameter int unsigned DW    = 16,
   localparam int unsigned IW   = $clog2(NBINS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IW-1:0]        wr_idx,
   input  logic signed [DW-1:0] wr_re,
   input  logic signed [DW-1:0] wr_im,
   input  logic [IW-1:0]        rd_idx,
   output logic signed [DW-1:0] rd_re,
   output logic signed [DW-1:0] rd_im
);

   logic signed [DW-1:0] w_re [NBINS];
   logic signed [DW-1:0] w_im [NBINS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(NBINS); i++) begin
            w_re[i] <= '0;
            w_im[i] <= '0;
         end
      end else if (wr_en) begin
         w_re[wr_idx] <= wr_re;
         w_im[wr_idx] <= wr_im;
      end
   end

   assign rd_re = w_re[rd_idx];
   assign rd_im = w_im[rd_idx];

endmodule

// File: rtl/bpe_cmul.sv
module bpe_cmul #(
   parameter int unsigned DW  = 16,
   localparam int unsigned PW = 2*DW + 1
) (
   input  logic signed [DW-1:0] a_re,
   input  logic signed [DW-1:0] a_im,
   input  logic signed [DW-1:0] b_re,
   input  logic signed [DW-1:0] b_im,
   output logic signed [PW-1:0] p_re,
   output logic signed [PW-1:0] p_im
);

   logic signed [PW-1:0] rr, ii, ri, ir;

   always_comb begin
      rr   = PW'(a_re) * PW'(b_re);
      ii   = PW'(a_im) * PW'(b_im);
      ri   = PW'(a_re) * PW'(b_im);
      ir   = PW'(a_im) * PW'(b_re);
      p_re = rr - ii;
      p_im = ri + ir;
   end

endmodule

// File: rtl/bpe_hold_buf.sv
module bpe_hold_buf #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned PW    = 33,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_idx,
   input  logic signed [PW-1:0] wr_re,
   input  logic signed [PW-1:0] wr_im,
   input  logic [AW-1:0]        rd_idx,
   output logic signed [PW-1:0] rd_re,
   output logic signed [PW-1:0] rd_im
);

   logic signed [PW-1:0] h_re [DEPTH];
   logic signed [PW-1:0] h_im [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         h_re[wr_idx] <= wr_re;
         h_im[wr_idx] <= wr_im;
      end
   end

   assign rd_re = h_re[rd_idx];
   assign rd_im = h_im[rd_idx];

endmodule

// File: rtl/bpe_half_sum.sv
module bpe_half_sum #(
   parameter int unsigned PW  = 33,
   parameter int unsigned DW  = 16,
   localparam int unsigned SW = PW + 1
) (
   input  logic signed [PW-1:0] lo_term,
   input  logic signed [PW-1:0] hi_term,
   output logic signed [DW-1:0] y
);

   localparam logic signed [SW-1:0] HI_LIM = SW'((64'sd1 <<< (DW-1)) - 64'sd1);
   localparam logic signed [SW-1:0] LO_LIM = -HI_LIM - SW'(1);

   logic signed [SW-1:0] sum;
   logic signed [SW-1:0] halved;

   always_comb begin
      sum    = SW'(lo_term) + SW'(hi_term);
      halved = signed'(sum + SW'(1)) >>> 1;
      if (halved > HI_LIM)
         y = HI_LIM[DW-1:0];
      else if (halved < LO_LIM)
         y = LO_LIM[DW-1:0];
      else
         y = halved[DW-1:0];
   end

endmodule

// File: rtl/bin_pair_eq.sv
module bin_pair_eq
   import bpe_pkg::*;
#(
   parameter int unsigned NBINS = 128,
   parameter int unsigned DW    = 16,
   localparam int unsigned IW   = $clog2(NBINS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   input  logic                 in_last,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic signed [DW-1:0] out_re,
   output logic signed [DW-1:0] out_im,
   output logic                 out_last,
   input  logic                 cw_en,
   input  logic [IW-1:0]        cw_idx,
   input  logic signed [DW-1:0] cw_re,
   input  logic signed [DW-1:0] cw_im
);

   localparam int unsigned HALF = NBINS / 2;
   localparam int unsigned HW   = $clog2(HALF);
   localparam int unsigned PW   = 2*DW + 1;

   // Elaboration-time parameter checks.
   generate
      if ((NBINS % 2) != 0 || NBINS < 4) begin : g_bad_nbins
         $error("bin_pair_eq: NBINS must be even and at least 4");
      end
      if (DW < 2) begin : g_bad_dw
         $error("bin_pair_eq: DW must be at least 2");
      end
   endgenerate

   logic [IW-1:0] bin_cnt;
   seg_t          seg;
   logic [HW-1:0] pair_idx;
   logic          take;
   logic          blk_end;
   logic          coef_we;

   assign seg      = (bin_cnt >= IW'(HALF)) ? SEG_HI : SEG_LO;
   assign pair_idx = (seg == SEG_HI) ? HW'(bin_cnt - IW'(HALF)) : HW'(bin_cnt);
   assign in_ready = (seg == SEG_LO) || !out_valid || out_ready;
   assign take     = in_valid && in_ready;
   assign blk_end  = in_last || (bin_cnt == IW'(NBINS - 1));
   assign coef_we  = cw_en && (bin_cnt == '0) && !take;

   // Bin position within the current block.
   always_ff @(posedge clk) begin
      if (!rst_n)
         bin_cnt <= '0;
      else if (take)
         bin_cnt <= blk_end ? '0 : bin_cnt + IW'(1);
   end

   // Coefficient store, read at the arriving bin index.
   logic signed [DW-1:0] e_re, e_im;

   bpe_coef_mem #(.NBINS(NBINS), .DW(DW)) u_coef (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (coef_we),
      .wr_idx (cw_idx),
      .wr_re  (cw_re),
      .wr_im  (cw_im),
      .rd_idx (bin_cnt),
      .rd_re  (e_re),
      .rd_im  (e_im)
   );

   // Weighting of the arriving bin.
   logic signed [PW-1:0] prod_re, prod_im;

   bpe_cmul #(.DW(DW)) u_mul (
      .a_re (in_re),
      .a_im (in_im),
      .b_re (e_re),
      .b_im (e_im),
      .p_re (prod_re),
      .p_im (prod_im)
   );

   // Lower-half products wait here for their partners.
   logic signed [PW-1:0] park_re, park_im;

   bpe_hold_buf #(.DEPTH(HALF), .PW(PW)) u_park (
      .clk    (clk),
      .wr_en  (take && (seg == SEG_LO)),
      .wr_idx (pair_idx),
      .wr_re  (prod_re),
      .wr_im  (prod_im),
      .rd_idx (pair_idx),
      .rd_re  (park_re),
      .rd_im  (park_im)
   );

   // One half-sum lane per complex component.
   logic signed [PW-1:0] lane_lo [LANES];
   logic signed [PW-1:0] lane_hi [LANES];
   logic signed [DW-1:0] lane_y  [LANES];

   assign lane_lo[0] = park_re;
   assign lane_lo[1] = park_im;
   assign lane_hi[0] = prod_re;
   assign lane_hi[1] = prod_im;

   generate
      for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
         bpe_half_sum #(.PW(PW), .DW(DW)) u_hs (
            .lo_term (lane_lo[g]),
            .hi_term (lane_hi[g]),
            .y       (lane_y[g])
         );
      end
   endgenerate

   // Output holding register.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
      end else if (take && (seg == SEG_HI)) begin
         out_valid <= 1'b1;
         out_last  <= blk_end;
         out_re    <= lane_y[0];
         out_im    <= lane_y[1];
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/bpe_checker.sv
module bpe_checker #(
   parameter int unsigned NBINS = 128,
   parameter int unsigned DW    = 16,
   localparam int unsigned IW   = $clog2(NBINS),
   localparam int unsigned HALF = NBINS / 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic                 in_last,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic signed [DW-1:0] out_re,
   input logic signed [DW-1:0] out_im,
   input logic                 out_last,
   input logic [IW-1:0]        cnt
);

   // R7: a held output keeps its value.
   p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last)));

   // R10: a new output appears only after an upper-half bin was taken.
   p_rise_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready && (cnt >= IW'(HALF))));

   // R3: the block wraps after its final bin.
   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (cnt == IW'(NBINS - 1))) |=> (cnt == '0));

   // R9: an end flag returns the counter to bin 0.
   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> (cnt == '0));

   // R8: a stalled upper-half bin is not consumed.
   p_stall_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && out_valid && !out_ready && (cnt >= IW'(HALF))) |=> $stable(cnt));

endmodule

bind bin_pair_eq bpe_checker #(.NBINS(NBINS), .DW(DW)) u_bpe_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_re    (out_re),
   .out_im    (out_im),
   .out_last  (out_last),
   .cnt       (bin_cnt)
);

// File: tb/bin_pair_eq_test.sv
module bin_pair_eq_test;

   localparam int NBINS = 128;
   localparam int DW    = 16;
   localparam int HALF  = NBINS / 2;
   localparam int IW    = $clog2(NBINS);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic signed [DW-1:0] in_re = '0;
   logic signed [DW-1:0] in_im = '0;
   logic                 in_last = 1'b0;
   logic                 out_valid;
   logic                 out_ready = 1'b1;
   logic signed [DW-1:0] out_re;
   logic signed [DW-1:0] out_im;
   logic                 out_last;
   logic                 cw_en = 1'b0;
   logic [IW-1:0]        cw_idx = '0;
   logic signed [DW-1:0] cw_re = '0;
   logic signed [DW-1:0] cw_im = '0;

   bin_pair_eq #(.NBINS(NBINS), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im), .out_last(out_last),
      .cw_en(cw_en), .cw_idx(cw_idx), .cw_re(cw_re), .cw_im(cw_im)
   );

   always #5 clk = ~clk;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   bit stall_force = 1'b0;
   bit rdy_random = 1'b0;

   // Bench model state.
   int m_cnt = 0;
   int cre [NBINS];
   int cim [NBINS];
   longint hb_re [HALF];
   longint hb_im [HALF];

   // Scoreboard queues.
   int    q_re [$];
   int    q_im [$];
   bit    q_last [$];
   string q_req [$];

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int half_sat(input longint s);
      longint r;
      r = (s + 1) >>> 1;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      return int'(r);
   endfunction

   task automatic send_bin(input int re, input int im, input bit last, input string req);
      if (m_cnt < HALF) begin
         hb_re[m_cnt] = longint'(re) * cre[m_cnt] - longint'(im) * cim[m_cnt];
         hb_im[m_cnt] = longint'(re) * cim[m_cnt] + longint'(im) * cre[m_cnt];
      end else begin
         longint pr, pi;
         int k;
         k  = m_cnt - HALF;
         pr = longint'(re) * cre[m_cnt] - longint'(im) * cim[m_cnt];
         pi = longint'(re) * cim[m_cnt] + longint'(im) * cre[m_cnt];
         q_re.push_back(half_sat(hb_re[k] + pr));
         q_im.push_back(half_sat(hb_im[k] + pi));
         q_last.push_back(last || (m_cnt == NBINS - 1));
         q_req.push_back(req);
      end
      m_cnt = (last || m_cnt == NBINS - 1) ? 0 : m_cnt + 1;
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_re    = DW'(re);
      in_im    = DW'(im);
      in_last  = last;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic cw_write(input int idx, input int re, input int im);
      if (m_cnt == 0) begin
         cre[idx] = re;
         cim[idx] = im;
      end
      @(posedge clk); #1;
      cw_en  = 1'b1;
      cw_idx = IW'(idx);
      cw_re  = DW'(re);
      cw_im  = DW'(im);
      @(posedge clk); #1;
      cw_en  = 1'b0;
   endtask

   function automatic int rnd_s(input int mag);
      return int'($urandom_range(2 * mag)) - mag;
   endfunction

   // mode 0: small bins; 1: near-zero sums; 2: random; 3: full scale
   function automatic int bin_val(input int mode, input int i, input bit imag);
      case (mode)
         0: return rnd_s(1000);
         1: return imag ? -(i % 3) : ((i < HALF) ? (i % 5) - 2 : ((i * 3) % 7) - 3);
         2: return rnd_s(3000);
         default: return (i % 2 == 0) ? 32767 : -32768;
      endcase
   endfunction

   task automatic run_block(input int mode, input string req);
      for (int i = 0; i < NBINS; i++)
         send_bin(bin_val(mode, i, 1'b0), bin_val(mode, i, 1'b1), i == NBINS - 1, req);
   endtask

   // Output ready driver.
   always @(posedge clk) begin
      #1;
      if (stall_force) out_ready = 1'b0;
      else if (rdy_random) out_ready = ($urandom_range(2) != 0);
      else out_ready = 1'b1;
   end

   // Monitor.
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (q_re.size() == 0) begin
            chk(1'b0, "R10", "unexpected output", 1, 0);
         end else begin
            int er, ei;
            bit el;
            string rq;
            er = q_re.pop_front();
            ei = q_im.pop_front();
            el = q_last.pop_front();
            rq = q_req.pop_front();
            checks++;
            if (int'(out_re) != er || int'(out_im) != ei || out_last != el) begin
               errors++;
               $display("FAIL %s output: actual=(%0d,%0d,last=%0d) expected=(%0d,%0d,last=%0d)",
                        rq, out_re, out_im, out_last, er, ei, el);
            end
         end
      end
   end

   // Watchdog.
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "watchdog", "run did not finish", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NBINS; i++) begin cre[i] = 0; cim[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

      // R1: zero coefficients give zero output.
      run_block(2, "R1");

      // R3: unit-real weights, plain pair average.
      for (int i = 0; i < NBINS; i++) cw_write(i, 1, 0);
      run_block(0, "R3");

      // R4: near-zero sums of both signs.
      run_block(1, "R4");

      // R2: random complex weights and bins.
      for (int i = 0; i < NBINS; i++) cw_write(i, rnd_s(4000), rnd_s(4000));
      run_block(2, "R2");
      rdy_random = 1'b1;
      run_block(2, "R2");
      rdy_random = 1'b0;

      // R5: full-scale operands, both limits.
      for (int i = 0; i < NBINS; i++)
         cw_write(i, (i % 4 < 2) ? 32767 : -32768, (i % 3 == 0) ? -32768 : 32767);
      run_block(3, "R5");

      // R6: writes in mid-block are ignored, writes between blocks apply.
      for (int i = 0; i < NBINS; i++) cw_write(i, 2, -1);
      for (int i = 0; i < 10; i++) send_bin(rnd_s(1000), rnd_s(1000), 1'b0, "R6");
      cw_write(0, 500, 500);
      cw_write(HALF + 3, -700, 40);
      for (int i = 10; i < NBINS; i++) send_bin(rnd_s(1000), rnd_s(1000), i == NBINS - 1, "R6");
      run_block(0, "R6");
      cw_write(5, 900, -300);
      cw_write(HALF + 5, -11, 77);
      run_block(0, "R6");

      // R8/R7/R10: output held off.
      stall_force = 1'b1;
      for (int i = 0; i < HALF; i++) send_bin(rnd_s(1000), rnd_s(1000), 1'b0, "R10");
      @(negedge clk);
      chk(out_valid == 1'b0, "R10", "no output after lower half", out_valid, 0);
      chk(in_ready == 1'b1, "R8", "ready in lower half under stall", in_ready, 1);
      send_bin(rnd_s(1000), rnd_s(1000), 1'b0, "R7");
      @(posedge clk); #1;
      in_valid = 1'b1;
      begin
         logic signed [DW-1:0] h_re, h_im;
         @(negedge clk);
         h_re = out_re;
         h_im = out_im;
         for (int c = 0; c < 3; c++) begin
            chk(in_ready == 1'b0, "R8", "in_ready while output stalled", in_ready, 0);
            chk(out_valid == 1'b1 && out_re == h_re && out_im == h_im, "R7", "held output",
                out_re, h_re);
            @(negedge clk);
         end
      end
      in_valid = 1'b0;
      stall_force = 1'b0;
      for (int i = HALF + 1; i < NBINS; i++) send_bin(rnd_s(1000), rnd_s(1000), i == NBINS - 1, "R7");

      // R9: early end in upper half, then early end in lower half.
      for (int i = 0; i < HALF + 5; i++) send_bin(rnd_s(1000), rnd_s(1000), i == HALF + 4, "R9");
      run_block(0, "R9");
      for (int i = 0; i < 11; i++) send_bin(rnd_s(1000), rnd_s(1000), i == 10, "R9");
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R9", "no output after lower-half end", out_valid, 0);
      run_block(2, "R9");

      // Drain.
      repeat (20) @(posedge clk);
      chk(q_re.size() == 0, "R3", "pending expected outputs", q_re.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule